// File: doc/BRIEF.md
# Three-Channel Multi-Mode Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register port. Software writes a control byte that picks a channel, one of six output behaviours and binary or decimal (BCD) counting. It then writes the start value as two bytes to the channel's own address. Each channel has a count-enable input, which may carry a free-running tick or a train of external events, a trigger input whose rising edge restarts the triggered modes, and one output pin.

The supported behaviours are an end-of-count interrupt request, a retriggerable one-shot, a one-tick-low rate generator, a square wave, a strobe started by software and a strobe started by the trigger. The count can be read at any time, either live or through a snapshot that stays frozen until both of its bytes have been read. Everything runs on one clock. The count-enable and trigger inputs are sampled synchronously.

Top module: `interval_timer`

## Requirements
- R1: After reset every output is high, every counter is stopped with value 0, byte pointers point at the low byte and no snapshot is held.
- R2: A write to address 3 is a control byte. Bits [7:6] select the channel, where value 3 selects none. Bits [5:4] equal to 00 make a snapshot command. Any other value sets the mode from bits [3:1], where 6 acts as 2 and 7 acts as 3, and sets BCD from bit 0. Setting a mode stops the counter, resets both byte pointers, drops any snapshot and drives the output low in mode 0 and high in every other mode.
- R3: A channel's start value N is written to its address (0 to 2) as the low byte and then the high byte. Nothing starts until the high byte is written. While running, the count never exceeds N. An N of 0 means 65536 in binary and 10000 in BCD.
- R4: Mode 0: the output goes low at the load and goes high after N enabled ticks. It then stays high and the count stays at 0.
- R5: Mode 1: the load, or a trigger rising edge after a load, drives the output low and restarts the count at N. The output goes high after N ticks. A new edge during the pulse restarts the count.
- R6: Mode 2: the output is low for exactly one tick in every N ticks, when the count is 1, and the count reloads N after 1.
- R7: Mode 3: the count runs N down to 1 and repeats. The output is high while the count is above floor(N/2), so the output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R8: Mode 4: after the load the output stays high, goes low for one tick after N ticks, then goes high and the counter stops.
- R9: Mode 5: a load only arms the channel, and the output stays high. A trigger rising edge starts the count. The output goes low for one tick after N ticks. A new edge restarts the count.
- R10: In BCD mode the start value is read as four decimal digits, the counter wraps within 0 to 9999, and readback returns four BCD digits.
- R11: A read from a channel address returns the low byte and then the high byte of the live count, and each read advances the pointer.
- R12: A snapshot command captures the count. Later reads return the captured value, which stays frozen while the counter runs, until its high byte has been read. A second snapshot command while one is held is ignored.
- R13: In the same cycle, completing a load overrides a trigger edge, and a trigger edge overrides an enabled tick, so the count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 to 2 channels, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed channel (combinational) |
| cnt_en | input | 3 | Per-channel count enable (tick or event) |
| trig | input | 3 | Per-channel trigger, rising edge used |
| tout | output | 3 | Per-channel timer output |

## Verification
The bench holds the count enable on so that a trigger edge lands in the same cycle as a counting tick during a one-shot pulse and during a hardware strobe. The expected result is a restart from N rather than a decrement. In a second case it raises the trigger in the very cycle the high byte of a new value is written. In that case the load must win, so no strobe may follow. In both cases a behavioural model advanced on every clock judges the outputs cycle by cycle, and read checks confirm the reloaded counts.

// File: rtl/tmr_pkg.sv
// Package: shared widths, mode encoding and decimal conversion helpers
// for the interval timer. Assumes a 16-bit user count and a 17-bit
// internal count, so that the value 0 can stand for 65536.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int USER_W = 16;
    localparam int INT_W  = USER_W + 1;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_TC_IRQ    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_e;

    // Fold the two spare mode codes onto the periodic modes.
    function automatic mode_e norm_mode(input logic [MODE_W-1:0] m);
        case (m)
            3'd6:    norm_mode = M_RATE;
            3'd7:    norm_mode = M_SQUARE;
            default: norm_mode = mode_e'(m);
        endcase
    endfunction

    // Four BCD digits to a binary count; 0 stands for 10000.
    function automatic logic [INT_W-1:0] bcd_to_bin(input logic [USER_W-1:0] v);
        logic [INT_W-1:0] r;
        r = INT_W'(v[15:12]) * INT_W'(1000) + INT_W'(v[11:8]) * INT_W'(100)
          + INT_W'(v[7:4]) * INT_W'(10) + INT_W'(v[3:0]);
        if (r == '0) r = INT_W'(10000);
        return r;
    endfunction

    // Binary count (at most 10000) to four BCD digits, wrapping 10000 to 0.
    function automatic logic [USER_W-1:0] bin_to_bcd(input logic [INT_W-1:0] v);
        logic [INT_W-1:0] r;
        logic [19:0] acc;
        r = (v >= INT_W'(10000)) ? v - INT_W'(10000) : v;
        acc = '0;
        for (int i = INT_W - 1; i >= 0; i--) begin
            for (int d = 0; d < 5; d++) begin
                if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
            end
            acc = {acc[18:0], r[i]};
        end
        return USER_W'(acc);
    endfunction
endpackage

// File: rtl/tmr_edge.sv
// Rising-edge detector for a trigger input. Assumes the input is already
// synchronous to clk. One cycle of the edge pulse per low-to-high change.
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    // Remember the previous level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/tmr_readback.sv
// Readback path of one channel: byte pointer plus snapshot register.
// Assumes a read strobe and a snapshot command never share a cycle;
// if they do, the read is served and the snapshot command is dropped.
module tmr_readback
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [USER_W-1:0] live,
    input  logic              clear,
    input  logic              latch_cmd,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rbyte
);
    logic              latched_q;
    logic              rptr_q;
    logic [USER_W-1:0] lat_val_q;
    logic [USER_W-1:0] src;

    // Track the byte pointer and the frozen snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
            lat_val_q <= '0;
        end else if (clear) begin
            latched_q <= 1'b0;
            rptr_q    <= 1'b0;
        end else if (rd_stb) begin
            rptr_q <= ~rptr_q;
            if (rptr_q) latched_q <= 1'b0;
        end else if (latch_cmd && !latched_q) begin
            lat_val_q <= live;
            latched_q <= 1'b1;
        end
    end

    // Select the source word and the byte the pointer names.
    always_comb begin
        src   = latched_q ? lat_val_q : live;
        rbyte = rptr_q ? src[15:8] : src[7:0];
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !rd_stb && !clear) |=> (latched_q && $stable(lat_val_q))); // R12
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: mode register, two-byte load assembly and the
// down counter with its six output behaviours. Assumes cnt_en and trig
// are synchronous to clk; an enabled tick is one count step.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_set,
    input  logic              ctl_latch,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              ctl_bcd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cnt_en,
    input  logic              trig,
    output logic [BYTE_W-1:0] rbyte,
    output logic              tout
);
    mode_e             mode_q;
    logic              bcd_q, wptr_q, armed_q, run_q, out_q;
    logic [BYTE_W-1:0] lo_q;
    logic [INT_W-1:0]  cnt_q, rel_q;
    logic [INT_W-1:0]  load_val, cnt_dec, sq_next;
    logic [USER_W-1:0] new_word, live;
    logic              load_now, trig_rise, trig_go, tick;

    tmr_edge i_edge (.clk(clk), .rst_n(rst_n), .sig(trig), .rise(trig_rise));

    // Decode the load value, the trigger action and the next counts.
    always_comb begin
        new_word  = {wdata, lo_q};
        load_now  = data_wr && wptr_q;
        if (bcd_q)                load_val = bcd_to_bin(new_word);
        else if (new_word == '0)  load_val = INT_W'(1) << USER_W;
        else                      load_val = INT_W'(new_word);
        trig_go   = trig_rise && armed_q && (mode_q == M_ONESHOT || mode_q == M_HW_STROBE);
        tick      = run_q && cnt_en;
        cnt_dec   = cnt_q - INT_W'(1);
        sq_next   = (cnt_q == INT_W'(1)) ? rel_q : cnt_dec;
        live      = bcd_q ? bin_to_bcd(cnt_q) : cnt_q[USER_W-1:0];
    end

    // Mode register, load assembly and counting, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_TC_IRQ;
            bcd_q   <= 1'b0;
            wptr_q  <= 1'b0;
            lo_q    <= '0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            out_q   <= 1'b1;
            cnt_q   <= '0;
            rel_q   <= '0;
        end else if (ctl_set) begin
            mode_q  <= norm_mode(ctl_mode);
            bcd_q   <= ctl_bcd;
            wptr_q  <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            out_q   <= (norm_mode(ctl_mode) != M_TC_IRQ);
        end else begin
            if (data_wr) begin
                wptr_q <= ~wptr_q;
                if (!wptr_q) lo_q <= wdata;
            end
            if (load_now) begin
                rel_q   <= load_val;
                cnt_q   <= load_val;
                armed_q <= 1'b1;
                run_q   <= (mode_q != M_HW_STROBE);
                out_q   <= !(mode_q == M_TC_IRQ || mode_q == M_ONESHOT);
            end else if (trig_go) begin
                cnt_q <= rel_q;
                run_q <= 1'b1;
                out_q <= (mode_q != M_ONESHOT);
            end else if (tick) begin
                case (mode_q)
                    M_TC_IRQ, M_ONESHOT: begin
                        cnt_q <= cnt_dec;
                        if (cnt_q == INT_W'(1)) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end
                    end
                    M_RATE: begin
                        cnt_q <= sq_next;
                        out_q <= (sq_next != INT_W'(1));
                    end
                    M_SQUARE: begin
                        cnt_q <= sq_next;
                        out_q <= (sq_next > (rel_q >> 1));
                    end
                    default: begin
                        if (cnt_q == '0) begin
                            out_q <= 1'b1;
                            run_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_dec;
                            out_q <= (cnt_q != INT_W'(1));
                        end
                    end
                endcase
            end
        end
    end

    tmr_readback i_rb (
        .clk(clk), .rst_n(rst_n), .live(live), .clear(ctl_set),
        .latch_cmd(ctl_latch), .rd_stb(data_rd), .rbyte(rbyte)
    );

    assign tout = out_q;

    AST_TC_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TC_IRQ && out_q && !ctl_set && !load_now) |=> out_q); // R4
    AST_RATE_LOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_RATE && !out_q && cnt_en && !ctl_set && !load_now) |=> out_q); // R6
    AST_HW_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HW_STROBE && !run_q) |-> out_q); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= rel_q)); // R3
    AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load_now && !trig_rise) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/interval_timer.sv
// Top of the three-channel interval timer: decodes the byte-wide
// register port into per-channel strobes and muxes read data back.
// Assumes NUM_CH is at most 3 so the control channel field fits [7:6].
module interval_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NUM_CH-1:0] cnt_en,
    input  logic [NUM_CH-1:0] trig,
    output logic [NUM_CH-1:0] tout
);
    logic                ctl_hit;
    logic [NUM_CH-1:0]   ch_set, ch_latch, data_wr, data_rd;
    logic [BYTE_W-1:0]   rbyte [NUM_CH];

    assign ctl_hit = wr_en && (addr == ADDR_W'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_set[g]   = ctl_hit && (wdata[7:6] == 2'(g)) && (wdata[5:4] != 2'b00);
        assign ch_latch[g] = ctl_hit && (wdata[7:6] == 2'(g)) && (wdata[5:4] == 2'b00);
        assign data_wr[g]  = wr_en && (addr == ADDR_W'(g));
        assign data_rd[g]  = rd_en && (addr == ADDR_W'(g));

        tmr_channel i_chan (
            .clk(clk), .rst_n(rst_n),
            .ctl_set(ch_set[g]), .ctl_latch(ch_latch[g]),
            .ctl_mode(wdata[3:1]), .ctl_bcd(wdata[0]),
            .data_wr(data_wr[g]), .data_rd(data_rd[g]), .wdata(wdata),
            .cnt_en(cnt_en[g]), .trig(trig[g]),
            .rbyte(rbyte[g]), .tout(tout[g])
        );
    end

    // Return the addressed channel's current byte, zero otherwise.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (data_rd[i]) rdata = rbyte[i];
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr, ctl_hit})); // R2
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [2:0] trig = '0, tout, cnt_en, en_man = '0;
    logic [7:0] lfsr = 8'hA5;
    int         en_src = 0;
    int         n_chk = 0, n_err = 0, cyc = 0;
    bit         cmp_on = 0, done = 0;

    int m_mode[3], m_bcd[3], m_wptr[3], m_lo[3], m_armed[3], m_run[3], m_out[3];
    int m_cnt[3], m_rel[3], m_lat[3], m_latv[3], m_rptr[3], m_tprev[3];

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .trig(trig), .tout(tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cnt_en = (en_src == 0) ? 3'b111 : (en_src == 1) ? lfsr[2:0] : en_man;
    always @(negedge clk) if (en_src == 1) lfsr <= {lfsr[6:0], lfsr[7]^lfsr[5]^lfsr[4]^lfsr[3]};

    function automatic string tag_of(int m);
        case (m)
            0: return "R4"; 1: return "R5"; 2: return "R6";
            3: return "R7"; 4: return "R8"; default: return "R9";
        endcase
    endfunction

    function automatic int rb(int c);
        int v;
        if (m_bcd[c] != 0) begin
            v = m_cnt[c] % 10000;
            return ((v/1000) << 12) | (((v/100)%10) << 8) | (((v/10)%10) << 4) | (v%10);
        end
        return m_cnt[c] % 65536;
    endfunction

    function automatic int model_byte(int c);
        int src;
        src = (m_lat[c] != 0) ? m_latv[c] : rb(c);
        return (m_rptr[c] != 0) ? ((src >> 8) & 255) : (src & 255);
    endfunction

    // Behavioural reference, advanced on every rising clock edge.
    always @(posedge clk) begin
        for (int c = 0; c < 3; c++) begin
            bit rise, ctl, is_set, is_lat, ld, rd;
            int n, val, nx;
            rise = trig[c] && (m_tprev[c] == 0);
            m_tprev[c] = rst_n ? int'(trig[c]) : 0;
            ctl = wr_en && addr == 2'd3 && int'(wdata[7:6]) == c;
            is_set = ctl && wdata[5:4] != 2'b00;
            is_lat = ctl && wdata[5:4] == 2'b00;
            rd = rd_en && int'(addr) == c;
            if (!rst_n) begin
                m_mode[c] = 0; m_bcd[c] = 0; m_wptr[c] = 0; m_lo[c] = 0; m_armed[c] = 0;
                m_run[c] = 0; m_out[c] = 1; m_cnt[c] = 0; m_rel[c] = 0;
                m_lat[c] = 0; m_latv[c] = 0; m_rptr[c] = 0;
            end else if (is_set) begin
                m_mode[c] = int'(wdata[3:1]);
                if (m_mode[c] >= 6) m_mode[c] = m_mode[c] - 4;
                m_bcd[c] = int'(wdata[0]); m_wptr[c] = 0; m_armed[c] = 0; m_run[c] = 0;
                m_out[c] = (m_mode[c] == 0) ? 0 : 1; m_lat[c] = 0; m_rptr[c] = 0;
            end else begin
                if (rd) begin
                    if (m_rptr[c] != 0) m_lat[c] = 0;
                    m_rptr[c] = 1 - m_rptr[c];
                end else if (is_lat && m_lat[c] == 0) begin
                    m_latv[c] = rb(c); m_lat[c] = 1;
                end
                ld = wr_en && int'(addr) == c && m_wptr[c] == 1;
                n = (int'(wdata) << 8) | m_lo[c];
                if (wr_en && int'(addr) == c) begin
                    if (m_wptr[c] == 0) m_lo[c] = int'(wdata);
                    m_wptr[c] = 1 - m_wptr[c];
                end
                if (m_bcd[c] != 0) begin
                    val = ((n>>12)&15)*1000 + ((n>>8)&15)*100 + ((n>>4)&15)*10 + (n&15);
                    if (val == 0) val = 10000;
                end else val = (n == 0) ? 65536 : n;
                if (ld) begin
                    m_rel[c] = val; m_cnt[c] = val; m_armed[c] = 1;
                    m_run[c] = (m_mode[c] == 5) ? 0 : 1;
                    m_out[c] = (m_mode[c] <= 1) ? 0 : 1;
                end else if (rise && m_armed[c] != 0 && (m_mode[c] == 1 || m_mode[c] == 5)) begin
                    m_cnt[c] = m_rel[c]; m_run[c] = 1; m_out[c] = (m_mode[c] == 1) ? 0 : 1;
                end else if (m_run[c] != 0 && cnt_en[c]) begin
                    if (m_mode[c] <= 1) begin
                        m_cnt[c]--;
                        if (m_cnt[c] == 0) begin m_out[c] = 1; m_run[c] = 0; end
                    end else if (m_mode[c] <= 3) begin
                        nx = (m_cnt[c] == 1) ? m_rel[c] : m_cnt[c] - 1;
                        m_cnt[c] = nx;
                        m_out[c] = (m_mode[c] == 2) ? ((nx != 1) ? 1 : 0) : ((nx > m_rel[c]/2) ? 1 : 0);
                    end else begin
                        if (m_cnt[c] == 0) begin m_out[c] = 1; m_run[c] = 0; end
                        else begin
                            m_out[c] = (m_cnt[c] == 1) ? 0 : 1; m_cnt[c]--;
                        end
                    end
                end
            end
        end
    end

    // Compare every output with the reference on every cycle.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int c = 0; c < 3; c++) begin
                n_chk++;
                if (int'(tout[c]) != m_out[c]) begin
                    n_err++;
                    $display("FAIL %s tout[%0d] mode %0d: actual %0b expected %0d",
                             tag_of(m_mode[c]), c, m_mode[c], tout[c], m_out[c]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1; n_err++;
            $display("FAIL watchdog (R1..all): actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_mode(input int ch, input int mode, input int bcd);
        wr(2'd3, {2'(ch), 2'b11, 3'(mode), 1'(bcd)});
    endtask

    task automatic load(input int ch, input int n);
        wr(2'(ch), 8'(n & 255));
        wr(2'(ch), 8'((n >> 8) & 255));
    endtask

    task automatic snap(input int ch);
        wr(2'd3, {2'(ch), 2'b00, 4'b0000});
    endtask

    task automatic rd_check(input int ch, input string tag);
        @(negedge clk); addr = 2'(ch); rd_en = 1'b1;
        #(CLK_PERIOD/4);
        chk(tag, int'(rdata), model_byte(ch));
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input int ch);
        @(negedge clk); trig[ch] = 1'b1;
        @(negedge clk); trig[ch] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1;
        idle(1);
        chk("R1 outputs after reset", int'(tout), 7);
        rd_check(0, "R1 count low byte");
        rd_check(0, "R1 count high byte");

        // Mode 0, then a partial load that must not start anything.
        set_mode(0, 0, 0);
        chk("R2 mode 0 output low", int'(tout[0]), 0);
        wr(2'd0, 8'd5);
        idle(3);
        rd_check(0, "R3 count before high byte");
        rd_check(0, "R3 count before high byte hi");
        wr(2'd0, 8'd0);
        idle(8);
        chk("R4 terminal count output", int'(tout[0]), 1);
        rd_check(0, "R4 count stays zero");
        rd_check(0, "R11 high byte");

        // Rate generator and square wave, full and irregular enables.
        set_mode(1, 2, 0); load(1, 4);
        set_mode(2, 3, 0); load(2, 5);
        idle(16);
        en_src = 1;
        idle(40);
        load(2, 6);
        idle(30);
        en_src = 0;
        set_mode(1, 6, 0); load(1, 3);
        idle(10);

        // Software strobe.
        set_mode(0, 4, 0); load(0, 3);
        idle(8);
        en_src = 1; load(0, 4); idle(20); en_src = 0;

        // One-shot with software start and retrigger during the pulse (R13).
        set_mode(1, 1, 0); load(1, 4);
        idle(8);
        pulse(1); idle(1); pulse(1);
        chk("R13 retrigger keeps pulse low", int'(tout[1]), 0);
        rd_check(1, "R13 count reloaded");
        idle(10);

        // Hardware strobe: armed only, then triggered and retriggered.
        set_mode(2, 5, 0); load(2, 3);
        idle(5);
        chk("R9 armed output high", int'(tout[2]), 1);
        pulse(2); idle(1); pulse(2);
        idle(8);

        // Decimal counting and zero meaning the maximum.
        set_mode(0, 2, 1); load(0, 16'h0012);
        idle(3);
        rd_check(0, "R10 decimal low byte");
        rd_check(0, "R10 decimal high byte");
        en_src = 2; en_man = 3'b000;
        set_mode(1, 0, 1); load(1, 0);
        rd_check(1, "R10 zero low"); rd_check(1, "R10 zero high");
        en_man = 3'b010; idle(1); en_man = 3'b000;
        rd_check(1, "R10 wrap low"); rd_check(1, "R10 wrap high");
        set_mode(2, 0, 0); load(2, 0);
        en_man = 3'b100; idle(1); en_man = 3'b000;
        rd_check(2, "R3 binary zero low"); rd_check(2, "R3 binary zero high");
        en_src = 0;

        // Snapshot frozen across reads while the counter runs.
        snap(0);
        idle(3);
        rd_check(0, "R12 snapshot low");
        idle(2);
        snap(0);
        idle(2);
        rd_check(0, "R12 snapshot high");
        idle(1);
        rd_check(0, "R11 live low");
        rd_check(0, "R11 live high");

        // Mode change while running stops the counter.
        set_mode(0, 2, 0);
        idle(4);
        rd_check(0, "R2 stopped count low");

        // High-byte write and trigger edge in the same cycle: load wins.
        set_mode(2, 5, 0); load(2, 3);
        wr(2'd2, 8'd3);
        @(negedge clk); addr = 2'd2; wdata = 8'd0; wr_en = 1'b1; trig[2] = 1'b1;
        @(negedge clk); wr_en = 1'b0; trig[2] = 1'b0;
        idle(6);
        chk("R13 load overrides trigger", int'(tout[2]), 1);
        pulse(2);
        idle(8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule